// File: doc/BRIEF.md
# Four-Lane Marker Deskew Buffer

This block sits behind four independently recovered serial lanes that already deliver decoded code groups: an 8-bit byte, a control flag and a valid strobe per lane, all on one core clock. Cable and per-lane clock recovery make the lanes arrive offset from one another. The transmitter places an alignment marker (control code K28.3, byte 0x7C with the control flag set) on all four lanes at the same instant during the gap between packets. The block uses those markers to cancel the offset.

Each lane owns a small buffer. While hunting, a lane throws away everything until its own marker arrives and then stores from the marker onward. When the last lane has stored its marker, all four buffers are drained together, one code group per lane per beat. The first released beat therefore carries the marker on every lane. If one lane runs too far ahead before the others show their marker, the block reports a skew error and starts over. After lock, a beat with the marker on only some lanes means lock has been lost, and the block also starts over.

Top module: `quad_lane_deskew`

## Requirements
- R1: A lane's input counts as the marker only when its valid strobe is high, its control flag is 1 and its byte is 0x7C. A 0x7C byte with the control flag at 0, or any other control byte, is ordinary data. While hunting, a lane discards every group that arrives before its own marker.
- R2: `dsk_aligned` rises in the cycle after the clock edge that captured the last lane's marker. In that same cycle `dsk_valid` is 1 and every lane's output carries the marker.
- R3: Once locked, each output beat holds, per lane, the next group of that lane's own stream, in arrival order, with no loss or duplication. Lane offsets of up to 4 code groups (40 UI at 10 bits per group) are removed.
- R4: `dsk_valid` is 1 only while locked and while every lane buffer holds at least one group. Whenever `dsk_valid` is 0, `dsk_data` and `dsk_ctrl` are all zero.
- R5: While hunting, if a lane that already has its marker receives the group that would bring its stored count above 5, the block raises `dsk_skew_err` for exactly the next cycle and does not lock. This holds even if the other markers arrive on that same edge. All buffers are flushed, every input on that edge is ignored, and the search restarts. A later aligned set of markers then locks normally.
- R6: While locked, a beat in which the buffer heads carry the marker on some lanes but not all is not released (`dsk_valid` 0). `dsk_aligned` falls in the next cycle, all buffers are flushed and the search restarts.
- R7: While locked, a valid group arriving at a lane whose buffer (8 entries) is full, in a cycle with no release, also counts as loss of lock: `dsk_aligned` falls in the next cycle.
- R8: Reset (`rst_n` low, asynchronous) empties all buffers and clears `dsk_aligned`, `dsk_valid` and `dsk_skew_err`. No output is valid before a lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock shared by all lanes and the output |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 32 | Lane bytes, lane n in bits [8n+7:8n] |
| rx_ctrl | input | 4 | Per-lane control flag |
| rx_valid | input | 4 | Per-lane valid strobe |
| dsk_data | output | 32 | Aligned lane bytes, same lane packing as the input, zero when not valid |
| dsk_ctrl | output | 4 | Aligned per-lane control flags, zero when not valid |
| dsk_valid | output | 1 | One aligned beat is presented this cycle |
| dsk_aligned | output | 1 | Block is locked |
| dsk_skew_err | output | 1 | One-cycle pulse: skew window exceeded while hunting |

## Verification
The bench goes after the skew boundary. An offset of exactly 4 groups must lock. An offset of 5, with the late markers on the very edge of the overrun, must give a skew error. A design with an off-by-one window would lock on the 5 case or fail on the 4 case. It checks the exact lock cycle and that the first beat is the marker on all lanes, which catches a design that releases one beat early or keeps idle groups from before the marker. Injected partial markers and a single-lane overrun must drop lock in the stated cycle. Relock after an error or slip exposes a controller that forgets to clear its per-lane marker state or its buffers. Random stalls and look-alike data bytes (0x7C without the control flag) check ordering and marker decoding.

// File: rtl/deskew_pkg.sv
package deskew_pkg;

  typedef enum logic {
    DSK_HUNT = 1'b0,
    DSK_LOCK = 1'b1
  } dsk_state_e;

  // number of set bits in a lane mask
  function automatic int unsigned lane_pop(input logic [31:0] mask);
    int unsigned n;
    n = 0;
    for (int b = 0; b < 32; b++) n += {31'd0, mask[b]};
    return n;
  endfunction

  // true when a write would push a buffer beyond the allowed fill
  function automatic logic window_overrun(input int unsigned fill, input logic wr,
                                          input int unsigned limit);
    return wr && (fill + 1 > limit);
  endfunction

endpackage

// File: rtl/lane_skew_fifo.sv
module lane_skew_fifo #(
  parameter int ENT_W = 9,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [ENT_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [ENT_W-1:0] rd_data,
  output logic [CNT_W-1:0] fill,
  output logic             empty,
  output logic             full
);

  logic [ENT_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] fill_q;
  logic             do_wr, do_rd;

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (fill_q == '0);
  assign full    = (32'(fill_q) == DEPTH);
  assign fill    = fill_q;
  assign rd_data = mem_q[rp_q];
  assign do_rd   = rd_en && !empty;
  assign do_wr   = wr_en && (!full || do_rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      fill_q <= '0;
    end else if (flush) begin
      wp_q   <= '0;
      rp_q   <= '0;
      fill_q <= '0;
    end else begin
      if (do_wr) wp_q <= ptr_step(wp_q);
      if (do_rd) rp_q <= ptr_step(rp_q);
      if (do_wr && !do_rd)      fill_q <= fill_q + 1'b1;
      else if (do_rd && !do_wr) fill_q <= fill_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr && !flush) mem_q[wp_q] <= wr_data;
  end

endmodule

// File: rtl/deskew_ctrl.sv
module deskew_ctrl
  import deskew_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int MAX_SKEW = 4,
  parameter int CNT_W    = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES-1:0]       in_valid,
  input  logic [LANES-1:0]       in_mark,
  input  logic [LANES*CNT_W-1:0] lane_fill,
  input  logic [LANES-1:0]       lane_empty,
  input  logic [LANES-1:0]       lane_full,
  input  logic [LANES-1:0]       head_mark,
  output logic [LANES-1:0]       wr_en,
  output logic                   rd_en,
  output logic                   flush,
  output logic                   aligned,
  output logic                   skew_err,
  output logic                   ev_lock,
  output logic                   ev_slip
);

  localparam int unsigned HUNT_LIMIT = MAX_SKEW + 1;

  dsk_state_e       st_q;
  logic [LANES-1:0] seen_q, seen_d;
  logic             skew_err_q;
  logic             ev_skew, heads_ok, mixed, overrun;
  int unsigned      head_marks;

  always_comb begin
    wr_en      = '0;
    seen_d     = seen_q;
    ev_skew    = 1'b0;
    ev_lock    = 1'b0;
    overrun    = 1'b0;
    heads_ok   = &(~lane_empty);
    head_marks = lane_pop(32'(head_mark));
    mixed      = heads_ok && (head_marks != 0) && (head_marks != LANES);
    rd_en      = (st_q == DSK_LOCK) && heads_ok && !mixed;
    if (st_q == DSK_HUNT) begin
      for (int i = 0; i < LANES; i++) begin
        wr_en[i]  = in_valid[i] && (seen_q[i] || in_mark[i]);
        seen_d[i] = seen_q[i] || (in_valid[i] && in_mark[i]);
        if (window_overrun(32'(lane_fill[i*CNT_W +: CNT_W]), wr_en[i], HUNT_LIMIT))
          ev_skew = 1'b1;
      end
      ev_lock = (&seen_d) && !ev_skew;
    end else begin
      wr_en = in_valid;
      for (int i = 0; i < LANES; i++)
        if (in_valid[i] && lane_full[i] && !rd_en) overrun = 1'b1;
    end
    ev_slip = (st_q == DSK_LOCK) && (mixed || overrun);
    flush   = ev_skew || ev_slip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= DSK_HUNT;
      seen_q     <= '0;
      skew_err_q <= 1'b0;
    end else begin
      skew_err_q <= ev_skew;
      if (flush) begin
        st_q   <= DSK_HUNT;
        seen_q <= '0;
      end else if (ev_lock) begin
        st_q   <= DSK_LOCK;
        seen_q <= '0;
      end else begin
        seen_q <= seen_d;
      end
    end
  end

  assign aligned  = (st_q == DSK_LOCK);
  assign skew_err = skew_err_q;

endmodule

// File: rtl/quad_lane_deskew.sv
module quad_lane_deskew #(
  parameter int              LANES      = 4,
  parameter int              DATA_W     = 8,
  parameter int              DEPTH      = 8,
  parameter int              MAX_SKEW   = 4,
  parameter logic [DATA_W-1:0] ALIGN_CODE = 8'h7C
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES*DATA_W-1:0] rx_data,
  input  logic [LANES-1:0]        rx_ctrl,
  input  logic [LANES-1:0]        rx_valid,
  output logic [LANES*DATA_W-1:0] dsk_data,
  output logic [LANES-1:0]        dsk_ctrl,
  output logic                    dsk_valid,
  output logic                    dsk_aligned,
  output logic                    dsk_skew_err
);

  localparam int ENT_W = DATA_W + 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [LANES-1:0]       in_mark, head_mark, wr_en, lane_empty, lane_full;
  logic [LANES*CNT_W-1:0] lane_cnt;
  logic [ENT_W-1:0]       head [LANES];
  logic                   rd_en, flush, lock_evt, slip_evt;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DATA_W-1:0] lane_byte;
    assign lane_byte    = rx_data[g*DATA_W +: DATA_W];
    assign in_mark[g]   = rx_ctrl[g] && (lane_byte == ALIGN_CODE);
    assign head_mark[g] = head[g][DATA_W] && (head[g][DATA_W-1:0] == ALIGN_CODE);

    lane_skew_fifo #(.ENT_W(ENT_W), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .wr_en   (wr_en[g]),
      .wr_data ({rx_ctrl[g], lane_byte}),
      .rd_en   (rd_en),
      .rd_data (head[g]),
      .fill    (lane_cnt[g*CNT_W +: CNT_W]),
      .empty   (lane_empty[g]),
      .full    (lane_full[g])
    );

    assign dsk_data[g*DATA_W +: DATA_W] = rd_en ? head[g][DATA_W-1:0] : '0;
    assign dsk_ctrl[g]                  = rd_en && head[g][DATA_W];
  end

  deskew_ctrl #(.LANES(LANES), .MAX_SKEW(MAX_SKEW), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (rx_valid),
    .in_mark    (in_mark),
    .lane_fill  (lane_cnt),
    .lane_empty (lane_empty),
    .lane_full  (lane_full),
    .head_mark  (head_mark),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .flush      (flush),
    .aligned    (dsk_aligned),
    .skew_err   (dsk_skew_err),
    .ev_lock    (lock_evt),
    .ev_slip    (slip_evt)
  );

  assign dsk_valid = rd_en;

endmodule

// File: rtl/quad_lane_deskew_chk.sv
module quad_lane_deskew_chk #(
  parameter int              LANES      = 4,
  parameter int              DATA_W     = 8,
  parameter int              MAX_SKEW   = 4,
  parameter int              CNT_W      = 4,
  parameter logic [DATA_W-1:0] ALIGN_CODE = 8'h7C
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [LANES*DATA_W-1:0] dsk_data,
  input logic [LANES-1:0]        dsk_ctrl,
  input logic                    dsk_valid,
  input logic                    dsk_aligned,
  input logic                    dsk_skew_err,
  input logic [LANES*CNT_W-1:0]  lane_cnt,
  input logic                    lock_evt,
  input logic                    slip_evt
);

  logic [LANES-1:0] out_marks;
  logic             hunt_fill_ok;

  always_comb begin
    hunt_fill_ok = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      out_marks[i] = dsk_ctrl[i] && (dsk_data[i*DATA_W +: DATA_W] == ALIGN_CODE);
      if (32'(lane_cnt[i*CNT_W +: CNT_W]) > MAX_SKEW + 1) hunt_fill_ok = 1'b0;
    end
  end

  AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    dsk_valid |-> dsk_aligned);                                              // R4
  AST_IDLE_OUTPUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dsk_valid |-> (dsk_data == '0 && dsk_ctrl == '0));                      // R4
  AST_FIRST_BEAT_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
    lock_evt |=> (dsk_aligned && dsk_valid && (&out_marks)));                 // R2
  AST_MARKER_ROW_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
    dsk_valid |-> (out_marks == '0 || (&out_marks)));                         // R6
  AST_SLIP_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    slip_evt |=> !dsk_aligned);                                               // R6
  AST_HUNT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !dsk_aligned |-> hunt_fill_ok);                                           // R5
  AST_ERR_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    dsk_skew_err |-> (!dsk_aligned && !dsk_valid));                           // R5

endmodule

bind quad_lane_deskew quad_lane_deskew_chk #(
  .LANES(LANES), .DATA_W(DATA_W), .MAX_SKEW(MAX_SKEW), .CNT_W(CNT_W),
  .ALIGN_CODE(ALIGN_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dsk_data(dsk_data), .dsk_ctrl(dsk_ctrl),
  .dsk_valid(dsk_valid), .dsk_aligned(dsk_aligned), .dsk_skew_err(dsk_skew_err),
  .lane_cnt(lane_cnt), .lock_evt(lock_evt), .slip_evt(slip_evt)
);

// File: tb/quad_lane_deskew_tb.sv
module quad_lane_deskew_tb;

  localparam int L    = 4;
  localparam int DW   = 8;
  localparam int MAXS = 4;
  localparam int PRE  = 2;
  localparam logic [7:0] MARK = 8'h7C;
  localparam logic [7:0] IDLE = 8'hBC;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [L*DW-1:0] rx_data = '0;
  logic [L-1:0]  rx_ctrl = '0, rx_valid = '0;
  logic [L*DW-1:0] dsk_data;
  logic [L-1:0]  dsk_ctrl;
  logic          dsk_valid, dsk_aligned, dsk_skew_err;

  int errors = 0;
  int checks = 0;
  logic [8:0] strm [L][64];
  int slen;

  always #5 clk = ~clk;

  quad_lane_deskew u_dut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_ctrl(rx_ctrl), .rx_valid(rx_valid),
    .dsk_data(dsk_data), .dsk_ctrl(dsk_ctrl), .dsk_valid(dsk_valid),
    .dsk_aligned(dsk_aligned), .dsk_skew_err(dsk_skew_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] rand_payload();
    int r;
    r = int'($urandom % 16);
    if (r == 0) return {1'b1, 8'hFB};
    if (r == 1) return {1'b0, MARK};   // look-alike, not a marker (R1)
    if (r == 2) return {1'b1, IDLE};
    return {1'b0, 8'($urandom)};
  endfunction

  task automatic drive_idle();
    rx_valid = '0; rx_ctrl = '0; rx_data = '0;
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    drive_idle();
    repeat (3) @(negedge clk);
    chk(!dsk_aligned && !dsk_valid && !dsk_skew_err, "R8", "outputs in reset",
        {dsk_aligned, dsk_valid, dsk_skew_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!dsk_aligned && !dsk_valid && dsk_data == '0, "R8", "outputs after reset",
        {dsk_aligned, dsk_valid}, 0);
  endtask

  task automatic run_case(input int d [L], input int npay, input int slip_at,
                          input int stall_pct, input bit do_reset);
    int mind, maxd, lock_step, err_step, exp_beats, rd, pos, step, idle_n, total;
    bit good;
    if (do_reset) apply_reset();
    slen = PRE + 1 + npay;
    for (int i = 0; i < L; i++) begin
      for (int k = 0; k < PRE; k++) strm[i][k] = {1'b1, IDLE};
      strm[i][PRE] = {1'b1, MARK};
      for (int k = 0; k < npay; k++) strm[i][PRE+1+k] = rand_payload();
    end
    if (slip_at >= 0) strm[0][PRE+1+slip_at] = {1'b1, MARK};
    mind = d[0]; maxd = d[0];
    for (int i = 1; i < L; i++) begin
      if (d[i] < mind) mind = d[i];
      if (d[i] > maxd) maxd = d[i];
    end
    good      = (maxd - mind) <= MAXS;
    lock_step = PRE + maxd;
    err_step  = PRE + mind + MAXS + 1;
    exp_beats = !good ? 0 : (slip_at >= 0 ? 1 + slip_at : npay + 1);
    total     = slen + maxd;
    rd = 0; pos = 0; step = 0; idle_n = 0;
    while (pos < total || idle_n < 6) begin
      @(negedge clk);
      if (dsk_valid) begin
        logic [35:0] got, exp;
        for (int i = 0; i < L; i++) begin
          got[i*9 +: 9] = {dsk_ctrl[i], dsk_data[i*DW +: DW]};
          exp[i*9 +: 9] = (rd < 64 - PRE) ? strm[i][PRE+rd] : 9'h0;
        end
        if (rd < exp_beats) chk(got == exp, (rd == 0) ? "R1" : "R3", "lane beat", got, exp);
        else chk(1'b0, "R3", "unexpected beat index", rd, exp_beats);
        rd++;
      end else begin
        chk(dsk_data == '0 && dsk_ctrl == '0, "R4", "idle outputs zero",
            {dsk_ctrl, dsk_data}, 0);
      end
      if (good && dsk_skew_err) chk(1'b0, "R5", "spurious skew error", 1, 0);
      if (good && step == lock_step)
        chk(!dsk_aligned, "R2", "not locked before last marker", dsk_aligned, 0);
      if (good && step == lock_step + 1)
        chk(dsk_aligned && dsk_valid, "R2", "lock cycle", {dsk_aligned, dsk_valid}, 2'b11);
      if (!good && step == err_step)
        chk(!dsk_skew_err, "R5", "error not early", dsk_skew_err, 0);
      if (!good && step == err_step + 1)
        chk(dsk_skew_err && !dsk_aligned, "R5", "skew error pulse",
            {dsk_skew_err, dsk_aligned}, 2'b10);
      if (pos >= total) begin
        drive_idle();
        idle_n++;
      end else if (pos > lock_step && int'($urandom % 100) < stall_pct) begin
        drive_idle();
      end else begin
        for (int i = 0; i < L; i++) begin
          int k;
          k = pos - d[i];
          if (k < 0) begin
            rx_valid[i] = 1'b1; rx_ctrl[i] = 1'b1; rx_data[i*DW +: DW] = IDLE;
          end else if (k < slen) begin
            rx_valid[i] = 1'b1; rx_ctrl[i] = strm[i][k][8]; rx_data[i*DW +: DW] = strm[i][k][7:0];
          end else begin
            rx_valid[i] = 1'b0; rx_ctrl[i] = 1'b0; rx_data[i*DW +: DW] = '0;
          end
        end
        pos++;
      end
      step++;
    end
    chk(rd == exp_beats, good ? (slip_at >= 0 ? "R6" : "R3") : "R5", "beat count", rd, exp_beats);
    chk(dsk_aligned == (good && slip_at < 0), (slip_at >= 0) ? "R6" : "R2", "final lock state",
        dsk_aligned, (good && slip_at < 0));
  endtask

  task automatic overflow_case();
    apply_reset();
    for (int s = 0; s <= 10; s++) begin
      if (s > 0) @(negedge clk);
      if (s == 1) chk(dsk_aligned && dsk_valid, "R7", "locked before overflow", dsk_aligned, 1);
      if (s == 9) chk(dsk_aligned, "R7", "still locked at full", dsk_aligned, 1);
      if (s == 10) chk(!dsk_aligned && !dsk_skew_err, "R7", "lock lost on overflow",
                       {dsk_aligned, dsk_skew_err}, 0);
      drive_idle();
      if (s == 0) begin
        rx_valid = '1; rx_ctrl = '1;
        for (int i = 0; i < L; i++) rx_data[i*DW +: DW] = MARK;
      end else if (s <= 9) begin
        rx_valid[0] = 1'b1; rx_data[DW-1:0] = 8'h11;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    process::self().srandom(32'd20240611);
    run_case('{0, 0, 0, 0}, 20, -1, 0, 1'b1);
    run_case('{0, 1, 2, 3}, 30, -1, 20, 1'b1);
    run_case('{4, 0, 2, 4}, 30, -1, 10, 1'b1);   // R3 maximum offset
    run_case('{3, 1, 4, 0}, 25, -1, 30, 1'b1);
    for (int n = 0; n < 5; n++)
      run_case('{int'($urandom % 5), int'($urandom % 5), int'($urandom % 5), int'($urandom % 5)},
               20 + int'($urandom % 20), -1, 25, 1'b1);
    run_case('{0, 5, 5, 5}, 15, -1, 0, 1'b1);    // R5 boundary, late markers on error edge
    run_case('{2, 0, 1, 3}, 15, -1, 10, 1'b0);   // R5 relock without reset
    run_case('{1, 7, 2, 3}, 15, -1, 0, 1'b1);
    run_case('{0, 2, 1, 3}, 20, 6, 0, 1'b1);     // R6 partial marker
    run_case('{1, 1, 0, 2}, 15, -1, 0, 1'b0);    // R6 relock after slip
    overflow_case();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule